// File: doc/BRIEF.md
# Supply-Loss Retention Sequencer

This block supervises a static memory across a failure of its main supply. Two digital comparator flags report the supply: one says the rail is inside its operating range (4.5 V or above), the other gives early warning that the rail is about to fall. The block registers an override that pins the memory chip select at its deselected level, and an access-grant flag for the memory controller. While the chip select is deselected, the memory performs no reads or writes and its data pins float. The memory keeps its contents at any rail voltage from 2.0 V to 5.5 V.

When the early warning arrives or the supply drops out of range, the override engages on the next clock edge. This keeps the 0 ns minimum power-down setup. The override stays on for as long as the supply is out of range. When the rail comes back cleanly, a recovery timer of at least 5 ms runs before the grant returns. The length of this timer, in clock cycles, is computed from the clock frequency. If the supply falters while the timer is running, the block goes back to retention and the timer starts again from zero. A host request that arrives while access is withheld is kept pending. It is acknowledged on the clock edge at which the grant returns.

Top module: `retention_seq`

## Requirements
- R1: While reset is asserted, and on the first edge after it, the chip-select override is 1, the grant is 0 and the acknowledge is 0.
- R2: With access granted, a warning flag of 1 sampled at a clock edge sets the override to 1 and the grant to 0 at that edge.
- R3: A supply-good flag of 0 sampled at a clock edge sets the override to 1 and the grant to 0 at that edge, from any state.
- R4: The override stays at 1 and the grant stays at 0 for every cycle in which the supply-good flag is 0.
- R5: After reset, or after retention, the grant returns only when the supply is good with no warning at L+1 consecutive edges. L = ceil(CLK_HZ*RECOVER_US/1e6) cycles. The grant rises on the (L+1)-th of those edges and not before.
- R6: A supply-good flag of 0 or a warning during recovery returns the block to retention. The full L+1 edge count then restarts once the supply is clean again.
- R7: If the warning clears while the supply never left its range, access still waits for the full recovery count of R5.
- R8: The override and the grant are always complementary.
- R9: With access granted, a one-cycle request pulse sampled at an edge produces a one-cycle acknowledge at that edge.
- R10: A request sampled while access is withheld is held pending. Its acknowledge is 1 on exactly the edge at which the grant rises, and 0 after that.
- R11: The acknowledge is never 1 while the grant is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Comparator flag: the rail is within its operating range |
| supply_warn | input | 1 | Comparator flag: early warning that the rail is about to fall |
| host_req | input | 1 | Host access request, one-cycle pulse |
| mem_cs_block | output | 1 | Forces the memory chip select to its deselected level |
| access_grant | output | 1 | Memory access is allowed |
| req_ack | output | 1 | One-cycle acknowledge of a request |

## Verification
The assertions assume that both comparator flags are already synchronous to the clock. They also assume that host requests are single-cycle pulses, so one pending slot is enough. The bench changes every input on the falling edge only, and it issues at most one request while access is withheld. The recovery window is checked by a counter of consecutive clean samples in the checker, not by a long delay in a property.

// File: rtl/retention_seq_pkg.sv
package retention_seq_pkg;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_DESEL   = 2'd1,
    ST_RETAIN  = 2'd2,
    ST_RECOVER = 2'd3
  } rs_state_e;

  // Recovery length in cycles, rounded up, never below 1.
  function automatic int unsigned recov_cycles(input longint unsigned clk_hz,
                                               input longint unsigned wait_us);
    longint unsigned c;
    c = (clk_hz * wait_us + 64'd999_999) / 64'd1_000_000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/rs_timer.sv
module rs_timer #(
  parameter int unsigned LIMIT = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expire
);
  localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign expire = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || expire) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rs_fsm.sv
module rs_fsm
  import retention_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      supply_ok,
  input  logic      supply_warn,
  input  logic      expire,
  output rs_state_e state_q,
  output rs_state_e state_d
);
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (!supply_ok)       state_d = ST_RETAIN;
        else if (supply_warn) state_d = ST_DESEL;
      end
      ST_DESEL: begin
        if (!supply_ok)        state_d = ST_RETAIN;
        else if (!supply_warn) state_d = ST_RECOVER;
      end
      ST_RETAIN: begin
        if (supply_ok && !supply_warn) state_d = ST_RECOVER;
      end
      ST_RECOVER: begin
        if (!supply_ok || supply_warn) state_d = ST_RETAIN;
        else if (expire)               state_d = ST_RUN;
      end
      default: state_d = ST_RETAIN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_RETAIN;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/rs_req_hold.sv
module rs_req_hold (
  input  logic clk,
  input  logic rst,
  input  logic host_req,
  input  logic run_next,
  output logic ack_q
);
  logic pend_q;
  logic ack_d;

  assign ack_d = run_next && (host_req || pend_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      pend_q <= (pend_q || host_req) && !ack_d;
      ack_q  <= ack_d;
    end
  end
endmodule

// File: rtl/retention_seq.sv
module retention_seq
  import retention_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 1_000_000,
  parameter int unsigned RECOVER_US = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok,
  input  logic supply_warn,
  input  logic host_req,
  output logic mem_cs_block,
  output logic access_grant,
  output logic req_ack
);
  localparam int unsigned LIMIT = recov_cycles(CLK_HZ, RECOVER_US);

  rs_state_e state_q, state_d;
  logic      expire;
  logic      run_next;

  assign run_next = (state_d == ST_RUN);

  rs_fsm u_fsm (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .supply_warn(supply_warn),
    .expire(expire), .state_q(state_q), .state_d(state_d)
  );

  rs_timer #(.LIMIT(LIMIT)) u_timer (
    .clk(clk), .rst(rst), .run(state_q == ST_RECOVER), .expire(expire)
  );

  rs_req_hold u_req (
    .clk(clk), .rst(rst), .host_req(host_req), .run_next(run_next), .ack_q(req_ack)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_cs_block <= 1'b1;
      access_grant <= 1'b0;
    end else begin
      mem_cs_block <= !run_next;
      access_grant <= run_next;
    end
  end
endmodule

// File: rtl/retention_seq_chk.sv
module retention_seq_chk #(
  parameter int unsigned LIMIT = 5000
) (
  input logic clk,
  input logic rst,
  input logic supply_ok,
  input logic supply_warn,
  input logic host_req,
  input logic mem_cs_block,
  input logic access_grant,
  input logic req_ack
);
  localparam int unsigned GW = $clog2(LIMIT + 2) + 1;
  logic [GW-1:0] good_cnt;

  always_ff @(posedge clk) begin
    if (rst)                             good_cnt <= '0;
    else if (!supply_ok || supply_warn)  good_cnt <= '0;
    else if (good_cnt != {GW{1'b1}})     good_cnt <= good_cnt + 1'b1;
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (mem_cs_block && !access_grant && !req_ack));

  assert_warn_block_R2: assert property (@(posedge clk) disable iff (rst)
    (access_grant && supply_warn) |=> (mem_cs_block && !access_grant));

  assert_loss_block_R3: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> (mem_cs_block && !access_grant));

  assert_recover_window_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(access_grant) |-> (good_cnt >= GW'(LIMIT)));

  assert_complement_R8: assert property (@(posedge clk) disable iff (rst)
    mem_cs_block != access_grant);

  assert_ack_granted_R11: assert property (@(posedge clk) disable iff (rst)
    req_ack |-> access_grant);
endmodule

bind retention_seq retention_seq_chk #(.LIMIT(LIMIT)) i_chk (
  .clk(clk), .rst(rst), .supply_ok(supply_ok), .supply_warn(supply_warn),
  .host_req(host_req), .mem_cs_block(mem_cs_block),
  .access_grant(access_grant), .req_ack(req_ack)
);

// File: tb/test_retention_seq.sv
module test_retention_seq;
  localparam int CLK_PERIOD = 10;
  localparam int unsigned TB_HZ = 100_000;
  localparam int unsigned TB_US = 5000;
  localparam int L = (TB_HZ * TB_US + 999_999) / 1_000_000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_ok = 1'b1;
  logic supply_warn = 1'b0;
  logic host_req = 1'b0;
  logic mem_cs_block, access_grant, req_ack;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  retention_seq #(.CLK_HZ(TB_HZ), .RECOVER_US(TB_US)) i_retention_seq (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .supply_warn(supply_warn),
    .host_req(host_req), .mem_cs_block(mem_cs_block),
    .access_grant(access_grant), .req_ack(req_ack)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic state_is(input string tag, input bit blk, input bit gnt, input bit ack);
    chk(mem_cs_block == blk, {tag, " block"}, mem_cs_block, blk);
    chk(access_grant == gnt, {tag, " grant"}, access_grant, gnt);
    chk(req_ack == ack, {tag, " ack"}, req_ack, ack);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Inputs went clean at the previous negedge; verify grant edge at L+1.
  task automatic expect_recovery(input string tag);
    step(L);
    chk(access_grant == 1'b0, {tag, " grant still low at L"}, access_grant, 0);
    step(1);
    chk(access_grant == 1'b1, {tag, " grant at L+1"}, access_grant, 1);
    chk(mem_cs_block == 1'b0, {tag, " block released"}, mem_cs_block, 0);
  endtask

  task automatic t_reset;
    step(3);
    state_is("R1 in reset", 1'b1, 1'b0, 1'b0);
    rst = 1'b0;
    step(1);
    state_is("R1 first edge", 1'b1, 1'b0, 1'b0);
    step(L);
    chk(access_grant == 1'b1, "R5 power-up grant at L+1", access_grant, 1);
  endtask

  task automatic t_req_run;
    host_req = 1'b1;
    step(1);
    host_req = 1'b0;
    state_is("R9 ack in run", 1'b0, 1'b1, 1'b1);
    step(1);
    state_is("R9 ack one cycle", 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_warn;
    supply_warn = 1'b1;
    step(1);
    state_is("R2 warn blocks", 1'b1, 1'b0, 1'b0);
    step(5);
    state_is("R8 warn held", 1'b1, 1'b0, 1'b0);
    supply_warn = 1'b0;
    expect_recovery("R7 warn cleared");
  endtask

  task automatic t_loss_req;
    supply_ok = 1'b0;
    step(1);
    state_is("R3 loss blocks", 1'b1, 1'b0, 1'b0);
    step(3);
    host_req = 1'b1;
    step(1);
    host_req = 1'b0;
    state_is("R11 no ack while withheld", 1'b1, 1'b0, 1'b0);
    step(6);
    state_is("R4 retention held", 1'b1, 1'b0, 1'b0);
    supply_ok = 1'b1;
    step(L);
    state_is("R10 pending before grant", 1'b1, 1'b0, 1'b0);
    step(1);
    state_is("R10 ack with grant", 1'b0, 1'b1, 1'b1);
    step(1);
    state_is("R10 ack single", 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_glitch;
    supply_ok = 1'b0;
    step(3);
    supply_ok = 1'b1;
    step(L / 2);
    state_is("R6 mid recovery", 1'b1, 1'b0, 1'b0);
    supply_ok = 1'b0;
    step(1);
    state_is("R6 glitch back to retention", 1'b1, 1'b0, 1'b0);
    supply_ok = 1'b1;
    expect_recovery("R6 restart");
  endtask

  initial begin
    t_reset;
    t_req_run;
    t_warn;
    t_loss_req;
    t_glitch;
    step(2);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule